// File: doc/BRIEF.md
# Five-Bit Shared-Function GPIO Port

This block is a five-bit general-purpose I/O port for a small controller. Each bit has three control bits: an output data latch, a drive-mode bit that picks full push-pull drive or open-drain drive, and a pull-up enable. Every bit can be set up on its own. An 8-bit register bus writes these registers and reads them back. A separate read-only register returns the synchronized levels on the pins.

The pins are shared with on-chip peripherals: interrupt inputs, a divided clock, UART transmit and receive, and a serial bus. A peripheral output is ANDed with the port latch, so it reaches the pad only while that latch bit is 1. An unused peripheral holds its output at 1. To use a pin as an input, software sets the latch bit to 1 and clears the drive-mode bit, which releases the pad.

Pad inputs pass through a two-flop synchronizer. They then feed both the pin-data register and the peripheral inputs. While the stop input is high, the input path is frozen. The pin-data register keeps its last value, and the peripheral inputs read as all ones. The block has no state machine. Its sequential state is the three control registers and the synchronizer.

Top module: `gpio_port5`

## Requirements
- R1: After reset the latch reads 0x1F, the drive-mode register reads 0x00 and the pull-up register reads 0x00.
- R2: The bus offsets are: 0 = latch, 1 = drive mode (1 = push-pull), 2 = pull-up enable, 3 = pin data. A write to offsets 0 to 2 stores bits 4:0. Read data bits 7:5 are always 0.
- R3: A write to offset 3 changes none of the registers.
- R4: `pad_out` bit i equals the latch bit i ANDed with `periph_out` bit i.
- R5: `pad_oe` bit i is 1 when drive-mode bit i is 1, or when `pad_out` bit i is 0.
- R6: `pad_pu` equals the pull-up enable register.
- R7: With stop low, a level on `pad_in` appears in the pin-data read (offset 3) and on `periph_in` after two rising clock edges.
- R8: While `stop_i` is high, `periph_in` is 0x1F and the pin-data read holds its value.
- R9: When the latch bit is 1, the drive-mode bit is 0 and the peripheral output is 1, the pad is released: `pad_oe` is 0 for that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current `bus_addr` (combinational) |
| periph_out | input | 5 | Peripheral output values; 1 when a peripheral is unused |
| stop_i | input | 1 | Stop mode; freezes the input path |
| pad_in | input | 5 | Raw pad levels |
| pad_out | output | 5 | Pad drive value |
| pad_oe | output | 5 | Pad output enable |
| pad_pu | output | 5 | Pad pull-up enable |
| periph_in | output | 5 | Synchronized pad levels for the peripherals |

## Verification
The assertions check on every cycle three safety properties. A pad is never released while driving 0. A cleared latch bit never lets a peripheral 1 reach the pad. Bits 7:5 of the read data are always 0. The assertions also check three timing properties on every cycle: a write to the pin-data offset leaves the registers unchanged, the synchronized value is frozen during stop, and it lags the pad by exactly two edges. Only the bench's scenarios can show the rest. Those are the reset values, correct readback at each offset under random write traffic, the AND with random peripheral outputs, and the release of a pin configured for input.

// File: rtl/gpio_port5_pkg.sv
package gpio_port5_pkg;
    localparam int unsigned PORT_W = 5;
    localparam int unsigned BUS_W  = 8;
    localparam int unsigned ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        OFS_LATCH = 2'd0,
        OFS_DRIVE = 2'd1,
        OFS_PULL  = 2'd2,
        OFS_PINS  = 2'd3
    } reg_ofs_e;

    localparam logic [PORT_W-1:0] LATCH_RST = '1;
    localparam logic [PORT_W-1:0] DRIVE_RST = '0;
    localparam logic [PORT_W-1:0] PULL_RST  = '0;
endpackage

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
    import gpio_port5_pkg::*;
#(
    parameter int unsigned W = PORT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      latch_q,
    output logic [W-1:0]      drive_q,
    output logic [W-1:0]      pull_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= LATCH_RST;
            drive_q <= DRIVE_RST;
            pull_q  <= PULL_RST;
        end else if (bus_wr) begin
            unique case (reg_ofs_e'(bus_addr))
                OFS_LATCH: latch_q <= wdata;
                OFS_DRIVE: drive_q <= wdata;
                OFS_PULL:  pull_q  <= wdata;
                OFS_PINS:  ;
            endcase
        end
    end

    // R3: the pin-data offset is read-only
    a_r3_ro_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_PINS) |=>
            ($stable(latch_q) && $stable(drive_q) && $stable(pull_q)));
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync
    import gpio_port5_pkg::*;
#(
    parameter int unsigned W = PORT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stop_i,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] pins_q,
    output logic [W-1:0] periph_in
);
    logic [W-1:0] stage1_q;
    logic [1:0]   warm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '1;
            pins_q   <= '1;
        end else if (!stop_i) begin
            stage1_q <= pad_in;
            pins_q   <= stage1_q;
        end
    end

    // counts run cycles for the latency check below
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            warm_q <= '0;
        else if (stop_i)       warm_q <= '0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end

    always_comb periph_in = stop_i ? {W{1'b1}} : pins_q;

    // R8: synchronized value is frozen during stop
    a_r8_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && $past(stop_i)) |-> $stable(pins_q));

    // R7: two-edge latency from pad to synchronized value
    a_r7_two_edges: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd3 && !stop_i) |-> (pins_q == $past(pad_in, 2)));
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
    import gpio_port5_pkg::*;
#(
    parameter int unsigned W = PORT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] latch_q,
    input  logic [W-1:0] drive_q,
    input  logic [W-1:0] pull_q,
    input  logic [W-1:0] periph_out,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_pu
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic eff;
        always_comb begin
            eff        = latch_q[i] & periph_out[i];
            pad_out[i] = eff;
            pad_oe[i]  = drive_q[i] | ~eff;
            pad_pu[i]  = pull_q[i];
        end
    end

    // R5: a released pad is never driving 0
    a_r5_release_high: assert property (@(posedge clk) disable iff (!rst_n)
        ((~pad_oe & ~pad_out) == '0));

    // R4: a cleared latch bit blocks the peripheral
    a_r4_latch_gates: assert property (@(posedge clk) disable iff (!rst_n)
        ((~latch_q & pad_out) == '0));
endmodule

// File: rtl/gpio_port5.sv
module gpio_port5
    import gpio_port5_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [PORT_W-1:0] periph_out,
    input  logic              stop_i,
    input  logic [PORT_W-1:0] pad_in,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_oe,
    output logic [PORT_W-1:0] pad_pu,
    output logic [PORT_W-1:0] periph_in
);
    localparam int unsigned PAD_BITS = BUS_W - PORT_W;

    logic [PORT_W-1:0] latch_q, drive_q, pull_q, pins_q;
    logic [PORT_W-1:0] rd_sel;

    gpio_ctrl_regs #(.W(PORT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .wdata(bus_wdata[PORT_W-1:0]),
        .latch_q(latch_q), .drive_q(drive_q), .pull_q(pull_q)
    );

    gpio_in_sync #(.W(PORT_W)) u_sync (
        .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .pad_in(pad_in),
        .pins_q(pins_q), .periph_in(periph_in)
    );

    gpio_pad_mux #(.W(PORT_W)) u_mux (
        .clk(clk), .rst_n(rst_n), .latch_q(latch_q), .drive_q(drive_q),
        .pull_q(pull_q), .periph_out(periph_out),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
    );

    always_comb begin
        unique case (reg_ofs_e'(bus_addr))
            OFS_LATCH: rd_sel = latch_q;
            OFS_DRIVE: rd_sel = drive_q;
            OFS_PULL:  rd_sel = pull_q;
            OFS_PINS:  rd_sel = pins_q;
        endcase
        bus_rdata = {{PAD_BITS{1'b0}}, rd_sel};
    end

    // R2: unused read bits are zero
    a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata[BUS_W-1:PORT_W] == '0));
endmodule

// File: tb/gpio_port5_tb.sv
`timescale 1ns/1ps
module gpio_port5_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [4:0] periph_out = 5'h1F;
    logic       stop_i = 1'b0;
    logic [4:0] pad_in = 5'h1F;
    logic [4:0] pad_out, pad_oe, pad_pu, periph_in;

    int n_chk = 0;
    int n_fail = 0;
    logic [4:0] m_lat, m_drv, m_pul, m_s1, m_s2;

    always #4 clk = ~clk;

    gpio_port5 u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .periph_out(periph_out),
        .stop_i(stop_i), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pu(pad_pu), .periph_in(periph_in)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0: return {3'b0, m_lat};
            2'd1: return {3'b0, m_drv};
            2'd2: return {3'b0, m_pul};
            default: return {3'b0, m_s2};
        endcase
    endfunction

    function automatic logic [4:0] exp_out(input logic [4:0] l, input logic [4:0] p);
        return l & p;
    endfunction

    function automatic logic [4:0] exp_oe(input logic [4:0] d, input logic [4:0] o);
        return d | ~o;
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input string req, input logic [1:0] a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    initial begin
        #1500000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        rd("R1 latch", 2'd0, 8'h1F);
        rd("R1 drive", 2'd1, 8'h00);
        rd("R1 pull", 2'd2, 8'h00);
        chk("R1 pad_out", {3'b0, pad_out}, 8'h1F);
        chk("R9 released after reset", {3'b0, pad_oe}, 8'h00);

        // R2 map and upper bits
        wr(2'd0, 8'hEA); rd("R2 latch", 2'd0, 8'h0A);
        wr(2'd1, 8'hF5); rd("R2 drive", 2'd1, 8'h15);
        wr(2'd2, 8'h33); rd("R2 pull", 2'd2, 8'h13);
        chk("R6 pad_pu", {3'b0, pad_pu}, 8'h13);
        chk("R4 pad_out", {3'b0, pad_out}, {3'b0, exp_out(5'h0A, 5'h1F)});
        chk("R5 pad_oe", {3'b0, pad_oe}, {3'b0, exp_oe(5'h15, 5'h0A)});

        // R3 write to pin data ignored
        wr(2'd3, 8'hFF);
        rd("R3 latch kept", 2'd0, 8'h0A);
        rd("R3 drive kept", 2'd1, 8'h15);
        rd("R3 pull kept", 2'd2, 8'h13);

        // R9 input configuration
        wr(2'd0, 8'h1F); wr(2'd1, 8'h00);
        periph_out = 5'h1F; #1;
        chk("R9 released", {3'b0, pad_oe}, 8'h00);
        periph_out = 5'h1B; #1;
        chk("R4 periph low", {3'b0, pad_out}, 8'h1B);
        chk("R5 low drives", {3'b0, pad_oe}, 8'h04);

        // R7 latency
        pad_in = 5'h0A; bus_addr = 2'd3;
        step();
        chk("R7 after one edge", {3'b0, periph_in}, 8'h1F);
        step();
        chk("R7 after two edges", {3'b0, periph_in}, 8'h0A);
        rd("R7 pin read", 2'd3, 8'h0A);

        // R8 stop
        stop_i = 1'b1; #1;
        chk("R8 periph ones", {3'b0, periph_in}, 8'h1F);
        pad_in = 5'h15;
        step(); step(); step();
        rd("R8 pin hold", 2'd3, 8'h0A);
        chk("R8 periph ones held", {3'b0, periph_in}, 8'h1F);
        stop_i = 1'b0;
        step(); step();
        rd("R7 after stop", 2'd3, 8'h15);

        // random traffic
        m_lat = 5'h1F; m_drv = 5'h00; m_pul = 5'h13;
        m_s1 = 5'h15; m_s2 = 5'h15;
        void'($urandom(32'd1234));
        for (int k = 0; k < 400; k++) begin
            logic [1:0] a;
            logic       w;
            logic [7:0] d;
            a = 2'($urandom_range(0, 3));
            w = 1'($urandom_range(0, 1));
            d = 8'($urandom);
            bus_addr = a; bus_wr = w; bus_wdata = d;
            periph_out = 5'($urandom);
            pad_in = 5'($urandom);
            step();
            bus_wr = 1'b0;
            if (w) begin
                case (a)
                    2'd0: m_lat = d[4:0];
                    2'd1: m_drv = d[4:0];
                    2'd2: m_pul = d[4:0];
                    default: ;
                endcase
            end
            m_s2 = m_s1; m_s1 = pad_in;
            chk("R2 random read", bus_rdata, exp_read(a));
            chk("R4 random out", {3'b0, pad_out}, {3'b0, exp_out(m_lat, periph_out)});
            chk("R5 random oe", {3'b0, pad_oe},
                {3'b0, exp_oe(m_drv, exp_out(m_lat, periph_out))});
            chk("R6 random pu", {3'b0, pad_pu}, {3'b0, m_pul});
            chk("R7 random sync", {3'b0, periph_in}, {3'b0, m_s2});
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule